// File: doc/BRIEF.md
# Restoring Binary Divider with Overflow Detection

This block divides an unsigned dividend of twice the divisor's width by an unsigned divisor and returns a quotient and a remainder that are each as wide as the divisor. The default configuration is 8-bit by 4-bit. All the work happens in one register that is one bit wider than the dividend. The register shifts left, and the vacated low bits collect the quotient as each bit is resolved. A comparator checks the upper slice of the register against the divisor and decides, each cycle, whether to subtract or only shift.

A pulse on `start` while the block is idle loads both operands. On the next cycle the controller makes a single comparison that shows whether the quotient fits in the quotient width. If it does not fit, the controller stops at once and raises the overflow flag. Otherwise it works through the quotient bits. Each bit costs one shift, plus one subtract cycle when that bit is 1, and the run ends with a last comparison. The controller is a one-hot state machine. `done` pulses for one cycle when the result or the overflow verdict is ready.

Top module: `restoring_divider`

## Requirements
- R1: After reset, `done` and `overflow` are 0.
- R2: If the dividend shifted right by four bits is greater than or equal to the divisor (a zero divisor always qualifies), `overflow` becomes 1 and `done` pulses on the clock edge right after the edge that accepted `start`.
- R3: When a division does not overflow, the cycle in which `done` is 1 shows `quotient` = floor(dividend / divisor), `remainder` = dividend mod divisor, and `overflow` = 0.
- R4: A division without overflow raises `done` exactly 5 + (number of 1 bits in the quotient) clock edges after the accepting edge, and `done` is never 1 for two cycles in a row.
- R5: `start` is ignored while a division is in progress, and it changes neither the timing nor the result of that division.
- R6: `overflow` keeps its value from the moment it is set until the next accepted `start` clears it.
- R7: A subtract step is issued only when the upper slice fits the divisor, and the comparison on the cycle after a subtract never fits.
- R8: The controller state is always exactly one-hot.
- R9: A shift and a subtract are never issued in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request a division; sampled only when idle |
| dividend | input | 8 | Unsigned dividend |
| divisor | input | 4 | Unsigned divisor |
| quotient | output | 4 | Quotient, valid when `done` shows no overflow |
| remainder | output | 4 | Remainder, valid with `quotient` |
| overflow | output | 1 | Quotient would not fit, or divisor is zero |
| done | output | 1 | One-cycle pulse when the outcome is ready |

## Verification
The assertion that a subtract is never followed by a fitting comparison depends on the operands having passed the overflow test. This is because the upper slice is then always less than twice the divisor. The zero-divisor property assumes `divisor` is stable in the cycle `start` is accepted. The stimulus drives operands only at falling edges and holds them through the accepting edge. Every combination of dividend and divisor is exercised, including extra `start` pulses during busy periods, so the properties see every reachable path through the controller.

// File: rtl/div_pkg.sv
package div_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'b001,
    ST_CHECK = 3'b010,
    ST_STEP  = 3'b100
  } div_state_t;
endpackage

// File: rtl/div_datapath.sv
module div_datapath #(
  parameter int DVD_W = 8,
  parameter int DVS_W = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     load,
  input  logic                     shift,
  input  logic                     sub,
  input  logic [DVD_W-1:0]         dividend,
  input  logic [DVS_W-1:0]         divisor,
  output logic                     fits,
  output logic [DVD_W-DVS_W-1:0]   quotient,
  output logic [DVS_W-1:0]         remainder
);
  localparam int REG_W = DVD_W + 1;
  localparam int HI_W  = DVS_W + 1;
  localparam int Q_W   = DVD_W - DVS_W;

  logic [REG_W-1:0] work_q;
  logic [DVS_W-1:0] dvs_q;
  logic [HI_W-1:0]  upper;
  logic [HI_W-1:0]  diff;

  // upper slice compared against the divisor
  function automatic logic slice_fits(input logic [HI_W-1:0] hi, input logic [DVS_W-1:0] d);
    return hi >= {1'b0, d};
  endfunction

  function automatic logic [HI_W-1:0] slice_minus(input logic [HI_W-1:0] hi, input logic [DVS_W-1:0] d);
    return hi - {1'b0, d};
  endfunction

  assign upper = work_q[REG_W-1:Q_W];
  assign fits  = slice_fits(upper, dvs_q);
  assign diff  = slice_minus(upper, dvs_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      work_q <= '0;
      dvs_q  <= '0;
    end else if (load) begin
      work_q <= {1'b0, dividend};
      dvs_q  <= divisor;
    end else if (sub) begin
      work_q <= {diff, work_q[Q_W-1:1], 1'b1};
    end else if (shift) begin
      work_q <= {work_q[REG_W-2:0], 1'b0};
    end
  end

  assign quotient  = work_q[Q_W-1:0];
  assign remainder = work_q[DVD_W-1:Q_W];
endmodule

// File: rtl/div_control.sv
module div_control
  import div_pkg::*;
#(
  parameter int Q_W = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       fits,
  output logic       load_ev,
  output logic       shift_ev,
  output logic       sub_ev,
  output logic       fin_ev,
  output logic       done,
  output logic       overflow,
  output logic [2:0] state_vec
);
  localparam int CW = $clog2(Q_W + 1);
  localparam logic [CW-1:0] LAST = CW'(Q_W);

  div_state_t state_q, state_d;
  logic [CW-1:0] cnt_q;
  logic          ovf_hit;
  logic          done_q, ovf_q;

  always_comb begin
    state_d  = state_q;
    load_ev  = 1'b0;
    shift_ev = 1'b0;
    sub_ev   = 1'b0;
    fin_ev   = 1'b0;
    ovf_hit  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          load_ev = 1'b1;
          state_d = ST_CHECK;
        end
      end
      ST_CHECK: begin
        if (fits) begin
          fin_ev  = 1'b1;
          ovf_hit = 1'b1;
          state_d = ST_IDLE;
        end else begin
          shift_ev = 1'b1;
          state_d  = ST_STEP;
        end
      end
      ST_STEP: begin
        if (fits) begin
          sub_ev = 1'b1;
        end else if (cnt_q == LAST) begin
          fin_ev  = 1'b1;
          state_d = ST_IDLE;
        end else begin
          shift_ev = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      done_q  <= 1'b0;
      ovf_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= fin_ev;
      if (load_ev)       cnt_q <= '0;
      else if (shift_ev) cnt_q <= cnt_q + 1'b1;
      if (load_ev)       ovf_q <= 1'b0;
      else if (ovf_hit)  ovf_q <= 1'b1;
    end
  end

  assign done      = done_q;
  assign overflow  = ovf_q;
  assign state_vec = state_q;
endmodule

// File: rtl/restoring_divider.sv
module restoring_divider #(
  parameter int DVD_W = 8,
  parameter int DVS_W = 4,
  localparam int Q_W = DVD_W - DVS_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [DVD_W-1:0] dividend,
  input  logic [DVS_W-1:0] divisor,
  output logic [Q_W-1:0]   quotient,
  output logic [DVS_W-1:0] remainder,
  output logic             overflow,
  output logic             done
);
  logic       load_ev, shift_ev, sub_ev, fin_ev, fits;
  logic [2:0] state_vec;

  div_control #(.Q_W(Q_W)) u_ctl (
    .clk(clk), .rst_n(rst_n), .start(start), .fits(fits),
    .load_ev(load_ev), .shift_ev(shift_ev), .sub_ev(sub_ev), .fin_ev(fin_ev),
    .done(done), .overflow(overflow), .state_vec(state_vec)
  );

  div_datapath #(.DVD_W(DVD_W), .DVS_W(DVS_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .load(load_ev), .shift(shift_ev), .sub(sub_ev),
    .dividend(dividend), .divisor(divisor), .fits(fits),
    .quotient(quotient), .remainder(remainder)
  );
endmodule

// File: rtl/div_checker.sv
module div_checker #(
  parameter int DVS_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic [DVS_W-1:0] divisor,
  input logic             done,
  input logic             overflow,
  input logic             load_ev,
  input logic             shift_ev,
  input logic             sub_ev,
  input logic             fits,
  input logic [2:0]       state_vec
);
  a_r2_zero_divisor: assert property (@(posedge clk) disable iff (!rst_n)
    (load_ev && divisor == '0) |-> ##2 (done && overflow));

  a_r4_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r6_overflow_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (overflow && !load_ev) |=> overflow);

  a_r7_sub_needs_fit: assert property (@(posedge clk) disable iff (!rst_n)
    sub_ev |-> fits);

  a_r7_no_fit_after_sub: assert property (@(posedge clk) disable iff (!rst_n)
    sub_ev |=> !fits);

  a_r8_state_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(state_vec) == 1);

  a_r9_shift_sub_apart: assert property (@(posedge clk) disable iff (!rst_n)
    !(shift_ev && sub_ev));
endmodule

bind restoring_divider div_checker #(.DVS_W(DVS_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .divisor(divisor), .done(done), .overflow(overflow),
  .load_ev(load_ev), .shift_ev(shift_ev), .sub_ev(sub_ev), .fits(fits),
  .state_vec(state_vec)
);

// File: tb/test_restoring_divider.sv
module test_restoring_divider;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [7:0] dividend = '0;
  logic [3:0] divisor = '0;
  logic [3:0] quotient, remainder;
  logic       overflow, done;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  // reference model state
  bit m_busy = 0;
  int m_left = 0;
  bit m_done = 0;
  bit m_ovf = 0;
  bit m_pend_ovf = 0;
  int m_q = 0;
  int m_r = 0;

  always #2 clk = ~clk;

  restoring_divider i_restoring_divider (
    .clk(clk), .rst_n(rst_n), .start(start), .dividend(dividend), .divisor(divisor),
    .quotient(quotient), .remainder(remainder), .overflow(overflow), .done(done)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cycles);
    end
  endtask

  // behavioural model advanced at every rising edge
  always @(posedge clk) begin
    cycles++;
    if (rst_n) begin
      m_done = 0;
      if (m_busy) begin
        m_left--;
        if (m_left == 0) begin
          m_busy = 0;
          m_done = 1;
          m_ovf  = m_pend_ovf;
        end
      end else if (start) begin
        m_busy = 1;
        m_ovf  = 0;
        m_pend_ovf = (divisor == 0) || ((int'(dividend) / 16) >= int'(divisor));
        if (!m_pend_ovf) begin
          m_q = int'(dividend) / int'(divisor);
          m_r = int'(dividend) % int'(divisor);
          m_left = 5 + $countones(m_q[3:0]);
        end else begin
          m_left = 1;
        end
      end
    end
  end

  // compare away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      check(done == m_done, "R4 done timing", int'(done), int'(m_done));
      check(overflow == m_ovf, "R2/R6 overflow", int'(overflow), int'(m_ovf));
      if (m_done && !m_pend_ovf) begin
        check(quotient == m_q[3:0], "R3 quotient", int'(quotient), m_q);
        check(remainder == m_r[3:0], "R3 remainder", int'(remainder), m_r);
      end
    end
  end

  task automatic run_div(input int a, input int b, input bit intrude);
    @(negedge clk);
    start = 1'b1;
    dividend = a[7:0];
    divisor = b[3:0];
    @(negedge clk);
    start = 1'b0;
    if (intrude) begin
      // R5: extra starts while busy
      start = 1'b1;
      dividend = ~a[7:0];
      divisor = b[3:0] + 4'd1;
      @(negedge clk);
      start = 1'b0;
    end
    while (m_busy) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(done == 1'b0, "R1 done after reset", int'(done), 0);
    check(overflow == 1'b0, "R1 overflow after reset", int'(overflow), 0);
    rst_n = 1'b1;
    @(negedge clk);
    // directed corners
    run_div(135, 13, 0);   // R3: 10 rem 5
    run_div(239, 15, 0);   // R3: largest fitting quotient
    run_div(16, 1, 0);     // R2: just overflows
    repeat (4) @(negedge clk);
    check(overflow == 1'b1, "R6 overflow held", int'(overflow), 1);
    run_div(200, 0, 0);    // R2: zero divisor
    run_div(15, 1, 1);     // R5: intrusion during run
    run_div(255, 15, 1);   // R5: intrusion after overflow
    run_div(0, 7, 0);      // R3: zero dividend
    // exhaustive sweep
    for (int b = 0; b < 16; b++)
      for (int a = 0; a < 256; a++)
        run_div(a, b, (a % 37) == 3);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(4 * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule